// File: doc/BRIEF.md
# Serial-Configured Clock Output Gate

This block sits beside the output stage of a multi-output clock generator and holds its small control bank. A host programs it over a two-wire serial bus (clock line plus open-drain data line). Every transaction names the block by its 7-bit device address and then streams bytes. There is no register address: the first data byte always lands in byte 0 and each further byte lands in the next slot. To reach a later slot, the host sends all the earlier ones again. The same bank can be read back, beginning at byte 0.

The bank powers up with usable defaults, so the serial bus is optional. Every clock output runs, spread spectrum is off and the output drivers are enabled. The bits drive three things: one gate per clock output, a global output-enable (tristate) control and a spread-spectrum mode code for the modulator that follows. The frequency-select strap pins are captured once after reset and can be read back, as can a fixed identification byte.

Bank layout with default parameters:

| Byte | Contents |
|------|----------|
| 0 | bit0 spread enable, bit1 wide center spread, bit2 tristate all outputs |
| 1 | bit0 down spread, bits 4:1 latched straps (read-only) |
| 2 and 3 | output enables |
| 4 | identification byte (read-only) |

Top module: `sercfg_clkgate`

## Requirements
- R1: After reset, clkOutEn is 1, spreadMode is 0 and every clkOut follows its clkIn. Reading the bank from byte 0 returns 0x00, the strap byte, 0xFF, 0xFF and then CHIP_ID (default 0xA5).
- R2: The first byte after a start carries the 7-bit device address DEV_ADDR (default 0x69) in bits 7:1 and a direction bit in bit 0 (0 write, 1 read). On any other address the block acknowledges nothing and changes nothing until the next start.
- R3: The block acknowledges each accepted byte by pulling the data line low for the whole ninth clock pulse. Accepted bytes are a matching address byte and every write data byte, including discarded ones.
- R4: Write data bytes load in order from byte 0, one slot per byte. A stop or a start returns the byte pointer to 0, so a later transaction starts again at byte 0.
- R5: A start is a falling data line while the serial clock is high, and it may be repeated inside a transaction. A stop is a rising data line while the clock is high. The block changes its own data drive only while the serial clock is low.
- R6: Output j (j from 0 to 7) is enabled by byte 2 bit j, and output 8+j by byte 3 bit j. When the bit is 1, clkOut[j] equals clkIn[j]. When it is 0, clkOut[j] stays low.
- R7: A new enable value reaches an output only while that output's clkIn is low. clkOut never rises or falls except together with clkIn, so no shortened pulse appears.
- R8: Byte 0 bit 2 set to 1 drives clkOutEn to 0, which places all outputs in high impedance. Set to 0, it drives clkOutEn to 1.
- R9: spreadMode is 0 when byte 0 bit 0 is 0. Otherwise it is 3 when byte 1 bit 0 is 1 (0.5% down spread, which overrides the center choice), else 2 when byte 0 bit 1 is 1 (wide center), else 1 (narrow center).
- R10: fsPins is captured in the first clock cycle after reset and reads back as byte 1 bits 4:1. Later pin changes and writes to those bits have no effect.
- R11: Byte 4 always reads CHIP_ID. A write to it is acknowledged and ignored.
- R12: Reserved bits (byte 0 bits 7:3, byte 1 bits 7:5) read as 0 whatever was written to them.
- R13: Write bytes beyond byte 4 are acknowledged and discarded.
- R14: A read returns bytes most-significant bit first, starting at byte 0. It continues while the host acknowledges, and returns 0x00 for slots past the last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; sampling and bank registers |
| rst | input | 1 | Asynchronous reset, active high |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaPullLow | output | 1 | 1 pulls the open-drain data line low |
| fsPins | input | STRAP_W | Frequency-select strap pins |
| clkIn | input | NUM_CLK | Ungated clock sources, one per output |
| clkOut | output | NUM_CLK | Gated clock outputs |
| clkOutEn | output | 1 | Output driver enable; 0 means all outputs tristated |
| spreadMode | output | 2 | Spread-spectrum mode code per R9 |

## Verification
A serial write can update an enable byte in the same cycle that the affected clock source is high. In that case the register update and the deferred gate change collide. The bench causes this collision on every output by sweeping walking-zero enable patterns. Each pattern lands at an arbitrary phase of sources running at three different periods, while a monitor sampling every cycle flags any edge on clkOut that does not coincide with an edge on clkIn. A second collision occurs when a repeated start clears the byte pointer while a write is still open. It is judged by which slot the next byte reaches, seen on spreadMode and clkOutEn.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  typedef struct packed {
    logic       wrStb;
    logic       ptrClr;
    logic       ptrInc;
    logic [7:0] wrByte;
  } bankCmd_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK_PEND,
    ST_AACK,
    ST_WDATA,
    ST_WACK_PEND,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_RNEXT,
    ST_SKIP
  } linkState_t;

  localparam logic [1:0] SPR_OFF    = 2'd0;
  localparam logic [1:0] SPR_NARROW = 2'd1;
  localparam logic [1:0] SPR_WIDE   = 2'd2;
  localparam logic [1:0] SPR_DOWN   = 2'd3;

endpackage

// File: rtl/sercfg_link_ctrl.sv
module sercfg_link_ctrl
  import sercfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output logic       sdaLow,
  output bankCmd_t   cmd
);

  logic [1:0] sclQ, sdaQ;
  logic       sclD, sdaD;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startEv, stopEv;

  linkState_t state;
  logic [2:0] bitCnt;
  logic [7:0] shReg;
  logic [7:0] txReg;
  logic       isRead;

  assign sclS = sclQ[1];
  assign sdaS = sdaQ[1];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sclQ <= 2'b11;
      sdaQ <= 2'b11;
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclQ <= {sclQ[0], sclIn};
      sdaQ <= {sdaQ[0], sdaIn};
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      shReg  <= '0;
      txReg  <= '0;
      isRead <= 1'b0;
      sdaLow <= 1'b0;
      cmd    <= '0;
    end else begin
      cmd.wrStb  <= 1'b0;
      cmd.ptrClr <= 1'b0;
      cmd.ptrInc <= 1'b0;
      if (startEv) begin
        state      <= ST_ADDR;
        bitCnt     <= '0;
        sdaLow     <= 1'b0;
        cmd.ptrClr <= 1'b1;
      end else if (stopEv) begin
        state      <= ST_IDLE;
        sdaLow     <= 1'b0;
        cmd.ptrClr <= 1'b1;
      end else begin
        unique case (state)
          ST_ADDR, ST_WDATA: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaS};
              bitCnt <= bitCnt + 3'd1;
              if (bitCnt == 3'd7)
                state <= (state == ST_ADDR) ? ST_AACK_PEND : ST_WACK_PEND;
            end
          end
          ST_AACK_PEND: begin
            if (sclFall) begin
              if (shReg[7:1] == DEV_ADDR) begin
                sdaLow <= 1'b1;
                isRead <= shReg[0];
                state  <= ST_AACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK, ST_RNEXT: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                txReg      <= rdByte;
                sdaLow     <= ~rdByte[7];
                cmd.ptrInc <= 1'b1;
                state      <= ST_RDATA;
              end else begin
                sdaLow <= 1'b0;
                state  <= ST_WDATA;
              end
            end
          end
          ST_WACK_PEND: begin
            if (sclFall) begin
              cmd.wrStb  <= 1'b1;
              cmd.wrByte <= shReg;
              cmd.ptrInc <= 1'b1;
              sdaLow     <= 1'b1;
              state      <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (sclFall) begin
              sdaLow <= 1'b0;
              bitCnt <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (sclFall) begin
              if (bitCnt == 3'd7) begin
                sdaLow <= 1'b0;
                state  <= ST_RACK;
              end else begin
                txReg  <= {txReg[6:0], 1'b0};
                sdaLow <= ~txReg[6];
                bitCnt <= bitCnt + 3'd1;
              end
            end
          end
          ST_RACK: begin
            if (sclRise) state <= sdaS ? ST_SKIP : ST_RNEXT;
          end
          default: ;
        endcase
      end
    end
  end

  // R5: own data drive only starts while the serial clock is low
  p_drive_low_phase_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sdaLow) |-> !sclS);

  // R2: nothing is driven when no transaction addresses this block
  p_quiet_unaddressed_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_SKIP) |-> !sdaLow);

  // R3: a stored write byte is always followed by an acknowledge drive
  p_write_acked_r3: assert property (@(posedge clk) disable iff (rst)
    cmd.wrStb |-> sdaLow);

endmodule

// File: rtl/sercfg_bank.sv
module sercfg_bank
  import sercfg_pkg::*;
#(
  parameter int         NUM_CLK = 16,
  parameter int         STRAP_W = 4,
  parameter logic [7:0] CHIP_ID = 8'hA5
) (
  input  logic               clk,
  input  logic               rst,
  input  bankCmd_t           cmdIn,
  input  logic [STRAP_W-1:0] fsPins,
  input  logic [NUM_CLK-1:0] clkIn,
  output logic [7:0]         rdByte,
  output logic [NUM_CLK-1:0] clkOut,
  output logic               clkOutEn,
  output logic [1:0]         spreadMode
);

  localparam int EN_BYTES  = (NUM_CLK + 7) / 8;
  localparam int EN_W      = EN_BYTES * 8;
  localparam int IDX_CTL   = 0;
  localparam int IDX_AUX   = 1;
  localparam int IDX_EN0   = 2;
  localparam int IDX_ID    = IDX_EN0 + EN_BYTES;
  localparam int WR_BYTES  = IDX_ID;
  localparam int NUM_BYTES = IDX_ID + 1;
  localparam int PW        = $clog2(NUM_BYTES + 1);
  localparam logic [EN_W-1:0] EN_MASK = {EN_W{1'b1}} >> (EN_W - NUM_CLK);

  logic [2:0]         ctlBits;   // {tristate, wide, spread on}
  logic               downSel;
  logic [EN_W-1:0]    enReg;
  logic [STRAP_W-1:0] straps;
  logic               strapTaken;
  logic [PW-1:0]      ptr;
  logic [NUM_CLK-1:0] gateEn;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ptr <= '0;
    end else if (cmdIn.ptrClr) begin
      ptr <= '0;
    end else if (cmdIn.ptrInc && ptr != PW'(NUM_BYTES)) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ctlBits <= '0;
      downSel <= 1'b0;
      enReg   <= EN_MASK;
    end else if (cmdIn.wrStb) begin
      if (ptr == PW'(IDX_CTL)) ctlBits <= cmdIn.wrByte[2:0];
      if (ptr == PW'(IDX_AUX)) downSel <= cmdIn.wrByte[0];
      for (int b = 0; b < EN_BYTES; b++) begin
        if (ptr == PW'(IDX_EN0 + b))
          enReg[b*8 +: 8] <= cmdIn.wrByte & EN_MASK[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      straps     <= '0;
      strapTaken <= 1'b0;
    end else if (!strapTaken) begin
      straps     <= fsPins;
      strapTaken <= 1'b1;
    end
  end

  always_comb begin
    rdByte = '0;
    if (ptr == PW'(IDX_CTL)) rdByte[2:0] = ctlBits;
    if (ptr == PW'(IDX_AUX)) begin
      rdByte[0]         = downSel;
      rdByte[STRAP_W:1] = straps;
    end
    for (int b = 0; b < EN_BYTES; b++) begin
      if (ptr == PW'(IDX_EN0 + b)) rdByte = enReg[b*8 +: 8];
    end
    if (ptr == PW'(IDX_ID)) rdByte = CHIP_ID;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      gateEn <= '1;
    end else begin
      for (int i = 0; i < NUM_CLK; i++) begin
        if (!clkIn[i]) gateEn[i] <= enReg[i];
      end
    end
  end

  assign clkOut   = clkIn & gateEn;
  assign clkOutEn = ~ctlBits[2];

  always_comb begin
    if (!ctlBits[0])    spreadMode = SPR_OFF;
    else if (downSel)   spreadMode = SPR_DOWN;
    else if (ctlBits[1]) spreadMode = SPR_WIDE;
    else                spreadMode = SPR_NARROW;
  end

  // R4: a start or stop brings the pointer back to byte 0
  p_ptr_clear_r4: assert property (@(posedge clk) disable iff (rst)
    cmdIn.ptrClr |=> (ptr == '0));

  // R13, R11: writes at or beyond the identification slot leave the bank intact
  p_discard_r13: assert property (@(posedge clk) disable iff (rst)
    (cmdIn.wrStb && ptr >= PW'(WR_BYTES)) |=>
      ($stable(enReg) && $stable(ctlBits) && $stable(downSel)));

  // R10: once captured, strap values never move
  p_strap_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (strapTaken && $past(strapTaken)) |-> $stable(straps));

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_runt
    // R7: gated output edges coincide with source edges
    p_rise_aligned_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(clkOut[g]) |-> $rose(clkIn[g]));
    p_fall_aligned_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(clkOut[g]) |-> $fell(clkIn[g]));
  end

endmodule

// File: rtl/sercfg_clkgate.sv
module sercfg_clkgate
  import sercfg_pkg::*;
#(
  parameter int         NUM_CLK  = 16,
  parameter int         STRAP_W  = 4,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] CHIP_ID  = 8'hA5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaPullLow,
  input  logic [STRAP_W-1:0] fsPins,
  input  logic [NUM_CLK-1:0] clkIn,
  output logic [NUM_CLK-1:0] clkOut,
  output logic               clkOutEn,
  output logic [1:0]         spreadMode
);

  bankCmd_t   bankCmd;
  logic [7:0] rdByte;

  sercfg_link_ctrl #(
    .DEV_ADDR(DEV_ADDR)
  ) i_link (
    .clk   (clk),
    .rst   (rst),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rdByte(rdByte),
    .sdaLow(sdaPullLow),
    .cmd   (bankCmd)
  );

  sercfg_bank #(
    .NUM_CLK(NUM_CLK),
    .STRAP_W(STRAP_W),
    .CHIP_ID(CHIP_ID)
  ) i_bank (
    .clk       (clk),
    .rst       (rst),
    .cmdIn     (bankCmd),
    .fsPins    (fsPins),
    .clkIn     (clkIn),
    .rdByte    (rdByte),
    .clkOut    (clkOut),
    .clkOutEn  (clkOutEn),
    .spreadMode(spreadMode)
  );

endmodule

// File: tb/test_sercfg_clkgate.sv
module test_sercfg_clkgate;

  localparam int         Q    = 8;
  localparam logic [6:0] DEV  = 7'h69;
  localparam logic [7:0] ID   = 8'hA5;
  localparam logic [3:0] STRP = 4'b1011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaBus;
  logic        sdaPullLow;
  logic [3:0]  fsPins = STRP;
  logic [15:0] clkIn = '0;
  logic [15:0] clkOut;
  logic        clkOutEn;
  logic [1:0]  spreadMode;

  int nChecks = 0;
  int nFails  = 0;
  int ackMiss = 0;
  int runtErr = 0;
  bit finished = 0;
  logic [7:0] txBuf [8];
  logic [7:0] rxBuf [8];
  logic [7:0] phase = '0;

  assign sdaBus = sdaM & ~sdaPullLow;

  always #2 clk = ~clk;

  sercfg_clkgate i_sercfg_clkgate (
    .clk(clk), .rst(rst), .sclIn(sclM), .sdaIn(sdaBus), .sdaPullLow(sdaPullLow),
    .fsPins(fsPins), .clkIn(clkIn), .clkOut(clkOut), .clkOutEn(clkOutEn),
    .spreadMode(spreadMode)
  );

  initial forever begin
    @(posedge clk); #1;
    phase = phase + 8'd1;
    for (int i = 0; i < 16; i++) clkIn[i] = phase[(i % 3) + 1];
  end

  initial begin
    logic [15:0] pIn, pOut;
    wait (rst == 1'b0);
    @(negedge clk);
    pIn = clkIn; pOut = clkOut;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 16; i++) begin
        if (clkOut[i] && !clkIn[i]) runtErr++;
        if (clkOut[i] != pOut[i] && clkIn[i] == pIn[i]) runtErr++;
      end
      pIn = clkIn; pOut = clkOut;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  task automatic waitq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaM = 1; waitq(); sclM = 1; waitq(); sdaM = 0; waitq(); sclM = 0; waitq();
  endtask

  task automatic busStop();
    sdaM = 0; waitq(); sclM = 1; waitq(); sdaM = 1; waitq();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitq(); sclM = 1; waitq(); waitq(); sclM = 0; waitq();
    end
    sdaM = 1; waitq(); sclM = 1; waitq(); ack = sdaBus; waitq(); sclM = 0; waitq();
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    sdaM = 1;
    for (int i = 7; i >= 0; i--) begin
      waitq(); sclM = 1; waitq(); b[i] = sdaBus; waitq(); sclM = 0;
    end
    waitq(); sdaM = nack; waitq(); sclM = 1; waitq(); waitq(); sclM = 0; waitq(); sdaM = 1;
  endtask

  task automatic doWrite(input int n);
    logic a;
    busStart();
    sendByte({DEV, 1'b0}, a); if (a) ackMiss++;
    for (int k = 0; k < n; k++) begin
      sendByte(txBuf[k], a); if (a) ackMiss++;
    end
    busStop();
    repeat (48) @(posedge clk);
  endtask

  task automatic doRead(input int n);
    logic a;
    busStart();
    sendByte({DEV, 1'b1}, a); if (a) ackMiss++;
    for (int k = 0; k < n; k++) recvByte(k == n - 1, rxBuf[k]);
    busStop();
    repeat (8) @(posedge clk);
  endtask

  task automatic gateCheck(input logic [15:0] en, input string tag);
    int bad = 0;
    logic [15:0] lastBad = '0;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      if (clkOut !== (clkIn & en)) begin bad++; lastBad = clkOut; end
    end
    check(bad == 0, tag, {16'h0, lastBad}, {16'h0, en});
  endtask

  initial begin
    logic a;
    logic [15:0] en;
    logic [1:0]  expMode;
    repeat (5) @(posedge clk);
    #1 rst = 0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(clkOutEn === 1'b1, "R1 reset clkOutEn", clkOutEn, 1);
    check(spreadMode === 2'd0, "R1 reset spreadMode", spreadMode, 0);
    gateCheck(16'hFFFF, "R1 reset outputs follow sources");

    // R1 R10 R11 R14: full read after reset, one slot past the end
    doRead(6);
    check(rxBuf[0] == 8'h00, "R1 byte0 default", rxBuf[0], 8'h00);
    check(rxBuf[1] == {3'b0, STRP, 1'b0}, "R10 strap byte", rxBuf[1], {3'b0, STRP, 1'b0});
    check(rxBuf[2] == 8'hFF && rxBuf[3] == 8'hFF, "R1 enable defaults", {rxBuf[3], rxBuf[2]}, 16'hFFFF);
    check(rxBuf[4] == ID, "R11 id byte", rxBuf[4], ID);
    check(rxBuf[5] == 8'h00, "R14 past last slot", rxBuf[5], 0);

    // R6 R7: walking-zero enable sweep plus a few full patterns
    for (int p = 0; p < 19; p++) begin
      if (p < 16) en = ~(16'h1 << p);
      else if (p == 16) en = 16'h0000;
      else if (p == 17) en = 16'hA5C3;
      else en = 16'hFFFF;
      txBuf[0] = 8'h00; txBuf[1] = 8'h00; txBuf[2] = en[7:0]; txBuf[3] = en[15:8];
      doWrite(4);
      gateCheck(en, $sformatf("R6 enable pattern %0d", p));
    end

    // R9 R12 R10: all spread combinations, reserved bits written as ones
    for (int m = 0; m < 8; m++) begin
      txBuf[0] = 8'hF8 | {6'b0, m[1], m[0]};
      txBuf[1] = 8'hFE | {7'b0, m[2]};
      doWrite(2);
      expMode = !m[0] ? 2'd0 : (m[2] ? 2'd3 : (m[1] ? 2'd2 : 2'd1));
      check(spreadMode == expMode, $sformatf("R9 spread combo %0d", m), spreadMode, expMode);
      doRead(2);
      check(rxBuf[0] == {6'b0, m[1], m[0]}, "R12 byte0 reserved", rxBuf[0], {6'b0, m[1], m[0]});
      check(rxBuf[1] == {3'b0, STRP, m[2]}, "R10 R12 byte1 readback", rxBuf[1], {3'b0, STRP, m[2]});
    end

    // R8: tristate on then off
    txBuf[0] = 8'h04; doWrite(1);
    check(clkOutEn === 1'b0, "R8 tristate set", clkOutEn, 0);
    txBuf[0] = 8'h00; doWrite(1);
    check(clkOutEn === 1'b1, "R8 tristate clear", clkOutEn, 1);

    // R11 R13 R3: write through the id slot and beyond
    ackMiss = 0;
    txBuf[0] = 8'h00; txBuf[1] = 8'h00; txBuf[2] = 8'hFF; txBuf[3] = 8'hFF;
    txBuf[4] = 8'h00; txBuf[5] = 8'h11; txBuf[6] = 8'h22;
    doWrite(7);
    check(ackMiss == 0, "R3 R13 every byte acknowledged", ackMiss, 0);
    doRead(6);
    check(rxBuf[4] == ID, "R11 id unchanged after write", rxBuf[4], ID);
    check(rxBuf[5] == 8'h00, "R13 R14 discarded slot reads zero", rxBuf[5], 0);

    // R2: foreign address ignored
    busStart();
    sendByte(8'h46, a);
    check(a === 1'b1, "R2 foreign address not acknowledged", a, 1);
    sendByte(8'h04, a);
    check(a === 1'b1, "R2 data after foreign address not acknowledged", a, 1);
    busStop();
    repeat (48) @(posedge clk);
    check(clkOutEn === 1'b1, "R2 foreign write had no effect", clkOutEn, 1);

    // R4: stop resets the pointer
    txBuf[0] = 8'h01; doWrite(1);
    check(spreadMode == 2'd1, "R4 first byte to slot 0", spreadMode, 1);
    txBuf[0] = 8'h00; doWrite(1);
    check(spreadMode == 2'd0, "R4 next transaction restarts at slot 0", spreadMode, 0);

    // R5 R4: repeated start inside an open write
    ackMiss = 0;
    busStart();
    sendByte({DEV, 1'b0}, a); if (a) ackMiss++;
    sendByte(8'h01, a); if (a) ackMiss++;
    busStart();
    sendByte({DEV, 1'b0}, a); if (a) ackMiss++;
    sendByte(8'h05, a); if (a) ackMiss++;
    busStop();
    repeat (48) @(posedge clk);
    check(ackMiss == 0, "R3 acks across repeated start", ackMiss, 0);
    check(clkOutEn === 1'b0 && spreadMode == 2'd1, "R5 repeated start restarts at slot 0",
          {clkOutEn, spreadMode}, {1'b0, 2'd1});
    txBuf[0] = 8'h00; doWrite(1);

    // R10: strap pins change after capture
    fsPins = ~STRP;
    doRead(2);
    check(rxBuf[1] == {3'b0, STRP, 1'b0}, "R10 later pin change ignored", rxBuf[1], {3'b0, STRP, 1'b0});

    check(runtErr == 0, "R7 output edges aligned with sources", runtErr, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule